// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block runs a single conversion on a four-channel, 12-bit successive-approximation converter attached over a synchronous serial link. One conversion is 24 serial clocks, sent as three back-to-back 8-clock byte transfers. The host offers a command through a valid/ready handshake. The command holds a 3-bit channel code, a mode bit, a single-ended/differential select and a 2-bit power-down code.

Once a command is accepted, the block lowers chip select and shifts out a control byte, most significant bit first. It then collects the 12 result bits that the converter returns during the second and third bytes. When the transfer ends it raises chip select, loads the result word and pulses a done flag for one cycle. The serial clock is produced from the system clock by a divider, `HALF_DIV` system clocks per half period.

The command side has back-pressure: `cmd_ready` is high only while the block is idle. Command fields are taken in the cycle where `cmd_valid` and `cmd_ready` are both high. A command offered while a conversion runs sees `cmd_ready` low and is dropped. The block does not queue it. The result side has no back-pressure. `res_data` holds the latest word until the next completion, and `res_done` marks the one cycle in which a new word appears.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: `cmd_ready` is high exactly when no conversion is running. A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. Commands offered while busy have no effect on the running transfer.
- R2: The control byte is sent MSB first as {1, addr[2:0], mode, sgl, pd[1:0]}. Its first bit (the start bit, 1) appears on `sdo` in the cycle after acceptance. `sdo` changes only while `sclk` is low.
- R3: Each conversion produces exactly 24 rising edges on `sclk`, with a period of 2*HALF_DIV system clocks. The first rising edge comes HALF_DIV cycles after acceptance.
- R4: `cs_n` goes low in the cycle after acceptance and stays low with no gap until the falling edge that follows the 24th rising edge. At that point it returns high.
- R5: `sclk` is high only while `cs_n` is low.
- R6: `sdi` is sampled on rising edges 10 through 21, counting from 1, and those bits form the result MSB first. Values on `sdi` at rising edges 1 to 9 and 22 to 24 do not affect the result.
- R7: `res_done` is a single-cycle pulse, 48*HALF_DIV cycles after acceptance. `res_data` changes only in that cycle and otherwise holds.
- R8: `busy` is high from the cycle after acceptance until the cycle in which `res_done` is high, when it is low.
- R9: After the eighth control bit, and whenever the block is idle, `sdo` is 0.
- R10: After reset, `cs_n` is 1 and `sclk`, `sdo`, `busy`, `res_done` and `res_data` are 0, while `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; command taken this cycle if valid |
| cmd_addr | input | 3 | Channel select code |
| cmd_mode | input | 1 | Mode bit sent to the converter |
| cmd_sgl | input | 1 | Single-ended (1) or differential (0) select |
| cmd_pd | input | 2 | Power-down code |
| busy | output | 1 | Conversion in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdo | output | 1 | Serial data to the converter |
| sdi | input | 1 | Serial data from the converter |
| res_data | output | 12 | Most recent conversion result |
| res_done | output | 1 | One-cycle pulse when `res_data` updates |

## Verification
The assertions assume the converter changes `sdi` only after a falling `sclk` edge. They also assume `sdi` then stays stable for at least one system clock before the next rising edge, which needs `HALF_DIV` of at least 2. The command fields matter only in the accept cycle. The bench's converter model updates `sdi` half a system clock after it sees `sclk` fall, so `sdi` is settled well before each sample. It drives ones or zeros on the unsampled clocks to show that those bits are ignored. Extra commands are offered only while a transfer is running, or back to back on the completion cycle, so the handshake stays within those assumptions.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;
  localparam int CTRL_BITS      = 8;
  localparam int RES_BITS       = 12;
  localparam int XFER_CLKS      = 24;
  localparam int HALF_STEPS     = 2 * XFER_CLKS;
  localparam int RES_FIRST_RISE = 10;
  localparam int RES_LAST_RISE  = RES_FIRST_RISE + RES_BITS - 1;

  typedef struct packed {
    logic [2:0] addr;
    logic       mode;
    logic       sgl;
    logic [1:0] pd;
  } adc_cmd_t;

  typedef enum logic {ST_IDLE, ST_RUN} xfer_state_t;

  function automatic logic [CTRL_BITS-1:0] make_ctrl(input adc_cmd_t c);
    return {1'b1, c};
  endfunction
endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // half-period ticks are never adjacent, so each sclk level lasts HALF_DIV cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ctrl_shifter.sv
module ctrl_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_out
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_out = sr[W-1];
endmodule

// File: rtl/res_capture.sv
module res_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)   sr <= '0;
    else if (clr) sr <= '0;
    else if (en)  sr <= {sr[W-2:0], din};
  end

  assign word = sr;

  // a transfer start and a data sample never coincide
  p_clr_en_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !en);
endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl
  import adc_xfer_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_addr,
  input  logic                cmd_mode,
  input  logic                cmd_sgl,
  input  logic [1:0]          cmd_pd,
  output logic                busy,
  output logic                cs_n,
  output logic                sclk,
  output logic                sdo,
  input  logic                sdi,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_done
);
  localparam int HW = $clog2(HALF_STEPS);
  localparam logic [HW-1:0] LAST_H = HW'(HALF_STEPS - 1);
  localparam logic [HW-2:0] WIN_LO = (HW-1)'(RES_FIRST_RISE - 1);
  localparam logic [HW-2:0] WIN_HI = (HW-1)'(RES_LAST_RISE - 1);

  xfer_state_t          state;
  logic [HW-1:0]        h;
  logic                 tick, rise_tick, fall_tick, accept, sample_en;
  logic [HW-2:0]        rise_idx;
  logic [CTRL_BITS-1:0] ctrl;
  logic [RES_BITS-1:0]  cap_word;
  adc_cmd_t             cmd;

  assign cmd       = '{addr: cmd_addr, mode: cmd_mode, sgl: cmd_sgl, pd: cmd_pd};
  assign ctrl      = make_ctrl(cmd);
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state == ST_RUN);
  assign accept    = cmd_valid && cmd_ready;
  assign rise_tick = tick && !h[0];
  assign fall_tick = tick && h[0];
  assign rise_idx  = h[HW-1:1];
  assign sample_en = rise_tick && (rise_idx >= WIN_LO) && (rise_idx <= WIN_HI);

  sclk_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  ctrl_shifter #(.W(CTRL_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(fall_tick),
    .din(ctrl), .bit_out(sdo)
  );

  res_capture #(.W(RES_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(sample_en),
    .din(sdi), .word(cap_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      h        <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      res_done <= 1'b0;
      res_data <= '0;
    end else begin
      res_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_RUN;
            h     <= '0;
            cs_n  <= 1'b0;
            sclk  <= 1'b0;
          end
        end
        default: begin
          if (tick) begin
            if (h == LAST_H) begin
              state    <= ST_IDLE;
              cs_n     <= 1'b1;
              sclk     <= 1'b0;
              res_done <= 1'b1;
              res_data <= cap_word;
            end else begin
              h    <= h + 1'b1;
              sclk <= ~sclk;
            end
          end
        end
      endcase
    end
  end

  p_sclk_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  p_sdo_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> $stable(res_data));

  p_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> res_done);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || res_done));

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !$rose(cs_n) || res_done);
endmodule

// File: tb/adc_xfer_ctrl_tb_top.sv
module adc_xfer_ctrl_tb_top;
  localparam int H    = 4;
  localparam int FULL = 48 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_addr = '0;
  logic        cmd_mode = 1'b0, cmd_sgl = 1'b0;
  logic [1:0]  cmd_pd = '0;
  logic        sdi = 1'b0;
  logic        cmd_ready, busy, cs_n, sclk, sdo, res_done;
  logic [11:0] res_data;

  int total = 0, fails = 0, cyc = 0;
  int t = -1;
  logic [7:0]  m_ctrl = '0;
  logic [11:0] m_res = '0, held_res = '0, conv_value = '0;
  logic        junk = 1'b0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          fcnt = 0, rcnt = 0;
  logic [7:0]  rx_byte = '0;

  always #5 clk = ~clk;

  adc_xfer_ctrl #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_mode(cmd_mode), .cmd_sgl(cmd_sgl), .cmd_pd(cmd_pd),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .res_data(res_data), .res_done(res_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: elapsed cycles since acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1;
      held_res = '0;
    end else if (t < 0 || t == FULL) begin
      if (cmd_valid) begin
        t = 0;
        m_ctrl = {1'b1, cmd_addr, cmd_mode, cmd_sgl, cmd_pd};
        m_res = conv_value;
      end else t = -1;
    end else begin
      t++;
      if (t == FULL) held_res = m_res;
    end
  end

  // converter model, byte collector and per-cycle comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b0; prev_cs = 1'b1; fcnt = 0; rcnt = 0;
    end else begin
      if (prev_cs && !cs_n) begin fcnt = 0; rcnt = 0; rx_byte = '0; end
      if (!prev_sclk && sclk) begin
        rcnt++;
        if (rcnt <= 8) rx_byte = {rx_byte[6:0], sdo};
      end
      if (prev_sclk && !sclk) fcnt++;
      if (!prev_cs && cs_n) begin
        chk(rcnt == 24, "R3 rising edges per conversion", rcnt, 24);
        chk(rx_byte == m_ctrl, "R2 control byte", rx_byte, m_ctrl);
      end
      sdi = (!cs_n && fcnt >= 9 && fcnt <= 20) ? conv_value[20 - fcnt] : junk;

      begin
        bit e_idle, e_sclk, e_sdo, e_done;
        int j, k;
        e_idle = (t < 0 || t == FULL);
        e_done = (t == FULL);
        e_sclk = 1'b0; e_sdo = 1'b0;
        if (!e_idle) begin
          j = t / H; k = j / 2;
          e_sclk = (j % 2) == 1;
          e_sdo  = (k < 8) ? m_ctrl[7 - k] : 1'b0;
        end
        chk(cmd_ready == e_idle, "R1 cmd_ready", cmd_ready, e_idle);
        chk(busy == !e_idle, "R8 busy", busy, !e_idle);
        chk(cs_n == e_idle, "R4 cs_n", cs_n, e_idle);
        chk(sclk == e_sclk, "R3 sclk", sclk, e_sclk);
        chk(sdo == e_sdo, "R2/R9 sdo", sdo, e_sdo);
        chk(res_done == e_done, "R7 res_done", res_done, e_done);
        chk(res_data == held_res, "R7 res_data", res_data, held_res);
        if (sclk) chk(!cs_n, "R5 sclk with cs_n", cs_n, 0);
        if (res_done) chk(res_data == m_res, "R6 result word", res_data, m_res);
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] a, input logic m, input logic s,
                       input logic [1:0] p, input logic [11:0] v, input logic jk,
                       input bit noisy);
    while (!cmd_ready) @(negedge clk);
    conv_value = v; junk = jk;
    cmd_addr = a; cmd_mode = m; cmd_sgl = s; cmd_pd = p;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (noisy) begin
      // R1: commands offered mid-transfer must be dropped
      repeat (30) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        cmd_addr = ~a; cmd_mode = ~m; cmd_sgl = ~s; cmd_pd = ~p;
        cmd_valid = 1'b1;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    while (!res_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R10 sclk after reset", sclk, 0);
    chk(sdo == 1'b0 && busy == 1'b0 && res_done == 1'b0, "R10 outputs idle",
        {sdo, busy, res_done}, 0);
    chk(res_data == '0 && cmd_ready, "R10 result and ready", res_data, 0);
    issue(3'd0, 1'b0, 1'b1, 2'd0, 12'hABC, 1'b0, 1'b0);
    issue(3'd7, 1'b1, 1'b0, 2'd3, 12'hFFF, 1'b1, 1'b0); // R6 junk ones ignored
    issue(3'd5, 1'b0, 1'b1, 2'd2, 12'h000, 1'b1, 1'b1); // R1 noisy
    issue(3'd2, 1'b1, 1'b1, 2'd1, 12'h555, 1'b0, 1'b0); // back to back
    issue(3'd6, 1'b0, 1'b0, 2'd3, 12'h801, 1'b1, 1'b1);
    issue(3'd1, 1'b1, 1'b0, 2'd0, 12'h3C6, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule